// File: doc/BRIEF.md
# AHB-Lite Word-Memory Subordinate

This block is an AHB-Lite subordinate in front of a small on-chip memory of 32-bit words. During the address phase it registers the target address, the direction and the transfer size. It does this only when it is selected, when the bus ready input is high, and when the transfer type is a real transfer. The data phase that follows is driven only by those registered copies. The address lines on the bus have already moved on to the next transfer at that point, so the block never uses them there.

An in-range access can be held for a fixed number of memory-latency wait states, set by a parameter from 0 to 3. An address past the end of the memory gets the two-cycle error response, and a faulting write leaves the memory unchanged. Byte and halfword writes are placed in the correct byte lanes. A read returns the whole word. The ready output and the error output are both driven from registers, so no bus input reaches them through logic alone.

Top module: `ahbl_mem_sub`

## Requirements
- R1: The data-phase read or write uses the address, direction and size registered in the address phase. The bus address presented during the data phase has no effect on which word is accessed.
- R2: A transfer is accepted only when `sel` is 1 and `bus_trans` is NONSEQ (2'b10) or SEQ (2'b11). The block ignores IDLE (2'b00), BUSY (2'b01), and any cycle with `sel` at 0. An ignored cycle does not write memory, and the cycle after it shows `ready_out`=1 and `resp_err`=0.
- R3: A BUSY cycle inside a burst adds no wait state and no error. The next SEQ beat of the burst is then carried out normally.
- R4: After an in-range transfer is accepted, `ready_out` stays low for exactly WAIT_STATES data-phase cycles and then goes high. When WAIT_STATES is 0 it never goes low.
- R5: An access at byte address MEM_WORDS*4 or above gets the error response. In the first data cycle `resp_err`=1 and `ready_out`=0. In the second data cycle `resp_err`=1 and `ready_out`=1. The memory is not written.
- R6: Every in-range transfer completes with `resp_err`=0.
- R7: During reset and after it, with no transfer pending, `ready_out`=1, `resp_err`=0 and `bus_rdata`=0.
- R8: Back-to-back transfers, where each address phase overlaps the previous data phase, each reach their own captured address.
- R9: `bus_size` 0 writes the byte lane selected by address bits [1:0]. `bus_size` 1 writes the halfword lane selected by address bit 1. `bus_size` 2 writes the whole word. Lane i is bits 8i+7:8i, little-endian.
- R10: A read returns the full 32-bit word on `bus_rdata` in the data cycle where `ready_out` is high.
- R11: When `bus_ready_in` is 0, the block does not sample a new address phase and keeps its registered control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Subordinate select from the decoder |
| bus_addr | input | ADDR_W | Byte address of the transfer |
| bus_trans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ or SEQ |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, valid in the data phase |
| bus_ready_in | input | 1 | Bus-wide ready; high when the previous transfer ends |
| ready_out | output | 1 | Ready from this subordinate; low inserts a wait |
| resp_err | output | 1 | Response: 1 for ERROR, 0 for OKAY |
| bus_rdata | output | 32 | Read data |

## Verification
The embedded assertions check on every cycle that the error pair has the right shape (low then high, with the error flag held), that the ready output is never low for longer than the configured latency, that the block is quiet whenever no data phase is pending, that a stalled bus freezes the registered control, and that no memory write happens while an error is being signalled. Assertions cannot see whether data reached the intended word. Only the bench scenarios can show this: readbacks after pipelined writes with a moving bus address, byte and halfword lane merging, the unchanged word behind an out-of-range write that would alias, and the ignored BUSY, IDLE and unselected cycles.

// File: rtl/ahbl_mem_pkg.sv
package ahbl_mem_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'b00,
    SQ_ERR_LO = 2'b01,
    SQ_ERR_HI = 2'b10
  } seq_e;

  // True for transfer types that carry data.
  function automatic logic is_xfer(input logic [1:0] t);
    return (t == TR_NSEQ) || (t == TR_SEQ);
  endfunction

  // Byte-lane mask from transfer size and the low address bits.
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz, input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      3'd0:    m = 4'b0001 << lo;
      3'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/amem_capture.sv
module amem_capture
  import ahbl_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_WORDS = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sel_i,
  input  logic                           rdy_i,
  input  logic [1:0]                     trans_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_i,
  input  logic [2:0]                     size_i,
  output logic                           acc_o,
  output logic                           acc_oob_o,
  output logic                           dp_vld_o,
  output logic                           dp_wr_o,
  output logic                           dp_oob_o,
  output logic [2:0]                     dp_size_o,
  output logic [$clog2(MEM_WORDS)+1:0]   dp_off_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OFF_W = $clog2(MEM_WORDS) + 2;
  localparam int LW    = ADDR_W + 1;
  localparam logic [LW-1:0] LIMIT = LW'(MEM_WORDS * LANES);

  assign acc_o     = sel_i && rdy_i && is_xfer(trans_i);
  assign acc_oob_o = acc_o && ({1'b0, addr_i} >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_vld_o  <= 1'b0;
      dp_wr_o   <= 1'b0;
      dp_oob_o  <= 1'b0;
      dp_size_o <= 3'd0;
      dp_off_o  <= '0;
    end else if (rdy_i) begin
      dp_vld_o <= acc_o;
      if (acc_o) begin
        dp_wr_o   <= wr_i;
        dp_oob_o  <= acc_oob_o;
        dp_size_o <= size_i;
        dp_off_o  <= addr_i[OFF_W-1:0];
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_i |=> $stable(dp_vld_o) && $stable(dp_off_o) && $stable(dp_wr_o)) else $error("capture moved during stall"); // R11
endmodule

// File: rtl/amem_resp.sv
module amem_resp
  import ahbl_mem_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic acc_oob_i,
  output logic ready_o,
  output logic err_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W   = (WAIT_STATES > 1) ? $clog2(WAIT_STATES + 1) : 1;
  localparam int MAX_LOW = (WAIT_STATES > 1) ? WAIT_STATES : 1;

  seq_e             st_q;
  seq_e             st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       low_run_q;

  generate
    if (WAIT_STATES == 0) begin : g_nowait
      assign cnt_q = '0;
    end else begin : g_cnt
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_STATES);
      always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (acc_i && !acc_oob_i) cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
      end
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:   if (acc_oob_i) st_d = SQ_ERR_LO;
      SQ_ERR_LO: st_d = SQ_ERR_HI;
      SQ_ERR_HI: st_d = acc_oob_i ? SQ_ERR_LO : SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign ready_o = (cnt_q == '0) && (st_q != SQ_ERR_LO);
  assign err_o   = (st_q != SQ_IDLE);

  // Length of the current low stretch of ready, for the bound check.
  always_ff @(posedge clk) begin
    if (!rst_n)                  low_run_q <= 3'd0;
    else if (ready_o)            low_run_q <= 3'd0;
    else if (low_run_q != 3'd7)  low_run_q <= low_run_q + 3'd1;
  end

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (low_run_q < 3'(MAX_LOW))) else $error("ready held low too long"); // R4
  AST_ERR_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !ready_o) else $error("error began with ready high"); // R5
  AST_ERR_SECOND_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !ready_o) |=> (err_o && ready_o)) else $error("error second cycle wrong"); // R5
  AST_NO_XFER_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !acc_i) |=> (ready_o && !err_o)) else $error("wait without a transfer"); // R3
endmodule

// File: rtl/amem_store.sv
module amem_store
  import ahbl_mem_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic                           clk,
  input  logic                           we_i,
  input  logic [LANES-1:0]               lanes_i,
  input  logic [$clog2(MEM_WORDS)-1:0]   idx_i,
  input  logic [BUS_W-1:0]               wdata_i,
  output logic [BUS_W-1:0]               rdata_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [BUS_W-1:0] mem [MEM_WORDS];
  logic [BUS_W-1:0] merged;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[8*g +: 8] = lanes_i[g] ? wdata_i[8*g +: 8] : mem[idx_i][8*g +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= merged;
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/ahbl_mem_sub.sv
module ahbl_mem_sub
  import ahbl_mem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MEM_WORDS   = 64,
  parameter int WAIT_STATES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_ready_in,
  output logic              ready_out,
  output logic              resp_err,
  output logic [BUS_W-1:0]  bus_rdata
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int OFF_W = IDX_W + 2;

  logic             acc, acc_oob;
  logic             dp_vld, dp_wr, dp_oob;
  logic [2:0]       dp_size;
  logic [OFF_W-1:0] dp_off;
  logic             mem_we;
  logic [LANES-1:0] mem_lanes;
  logic [BUS_W-1:0] mem_rd;

  amem_capture #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rdy_i(bus_ready_in),
    .trans_i(bus_trans), .addr_i(bus_addr), .wr_i(bus_write), .size_i(bus_size),
    .acc_o(acc), .acc_oob_o(acc_oob), .dp_vld_o(dp_vld), .dp_wr_o(dp_wr),
    .dp_oob_o(dp_oob), .dp_size_o(dp_size), .dp_off_o(dp_off)
  );

  amem_resp #(.WAIT_STATES(WAIT_STATES)) u_resp (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .acc_oob_i(acc_oob),
    .ready_o(ready_out), .err_o(resp_err)
  );

  // Data phase acts only on registered control; the write lands when ready is high.
  assign mem_we    = dp_vld && dp_wr && !dp_oob && ready_out;
  assign mem_lanes = lane_mask(dp_size, dp_off[1:0]);

  amem_store #(.MEM_WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .we_i(mem_we), .lanes_i(mem_lanes), .idx_i(dp_off[OFF_W-1:2]),
    .wdata_i(bus_wdata), .rdata_o(mem_rd)
  );

  assign bus_rdata = (dp_vld && !dp_wr && !dp_oob) ? mem_rd : '0;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_vld |-> (ready_out && !resp_err && bus_rdata == '0)) else $error("not quiet while idle"); // R7
  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !resp_err) else $error("memory written during error"); // R5
endmodule

// File: tb/ahbl_mem_sub_tb.sv
module ahbl_mem_sub_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WAITS = 1;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [31:0] a;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        oob;
  } vec_t;

  // Single transfers walked in order; reads compare against the running memory image.
  localparam vec_t VTAB [16] = '{
    '{1'b1, 3'd2, 32'h000, 32'hCAFE0001, 32'h0,        1'b0},
    '{1'b1, 3'd2, 32'h004, 32'h12345678, 32'h0,        1'b0},
    '{1'b0, 3'd2, 32'h000, 32'h0,        32'hCAFE0001, 1'b0},
    '{1'b0, 3'd2, 32'h004, 32'h0,        32'h12345678, 1'b0},
    '{1'b1, 3'd2, 32'h008, 32'h11223344, 32'h0,        1'b0},
    '{1'b1, 3'd0, 32'h009, 32'h0000AA00, 32'h0,        1'b0},
    '{1'b0, 3'd2, 32'h008, 32'h0,        32'h1122AA44, 1'b0},
    '{1'b1, 3'd1, 32'h00A, 32'hBEEF0000, 32'h0,        1'b0},
    '{1'b0, 3'd2, 32'h008, 32'h0,        32'hBEEFAA44, 1'b0},
    '{1'b1, 3'd2, 32'h0FC, 32'h0BADF00D, 32'h0,        1'b0},
    '{1'b1, 3'd2, 32'h100, 32'hFFFFFFFF, 32'h0,        1'b1},
    '{1'b0, 3'd2, 32'h000, 32'h0,        32'hCAFE0001, 1'b0},
    '{1'b0, 3'd2, 32'h200, 32'h0,        32'h0,        1'b1},
    '{1'b0, 3'd2, 32'h0FC, 32'h0,        32'h0BADF00D, 1'b0},
    '{1'b1, 3'd0, 32'h0FF, 32'h5A000000, 32'h0,        1'b0},
    '{1'b0, 3'd2, 32'h0FC, 32'h0,        32'h5AADF00D, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic        bus_write;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_ready_in;
  logic        ready_out;
  logic        resp_err;
  logic [31:0] bus_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  assign bus_ready_in = ready_out;

  ahbl_mem_sub #(.ADDR_W(32), .MEM_WORDS(64), .WAIT_STATES(WAITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .bus_addr(bus_addr), .bus_trans(bus_trans),
    .bus_write(bus_write), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready_in(bus_ready_in), .ready_out(ready_out), .resp_err(resp_err),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    sel = 1'b0; bus_trans = 2'b00; bus_write = 1'b0; bus_size = 3'd2;
  endtask

  // One transfer with an idle address phase behind it; the live address then points elsewhere.
  task automatic xfer(input bit wr, input logic [2:0] sz, input logic [31:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int nwait, output bit first_err, output bit last_err);
    @(negedge clk);
    sel = 1'b1; bus_trans = 2'b10; bus_addr = a; bus_write = wr; bus_size = sz;
    @(negedge clk);
    go_idle(); bus_addr = 32'h0000_0FF0; bus_wdata = wd;
    nwait = 0; first_err = 1'b0;
    while (ready_out !== 1'b1 && nwait < 8) begin
      if (nwait == 0) first_err = resp_err;
      nwait++;
      @(negedge clk);
    end
    last_err = resp_err;
    rd = bus_rdata;
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; int nw; bit fe, le;
    xfer(1'b0, 3'd2, a, 32'h0, rd, nw, fe, le);
    check(rd === exp, req, rd, exp);
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] rd; int nw; bit fe, le;
    xfer(1'b1, 3'd2, a, d, rd, nw, fe, le);
  endtask

  // A cycle that must start nothing.
  task automatic ghost(input logic s, input logic [1:0] tr, input string req);
    @(negedge clk);
    sel = s; bus_trans = tr; bus_addr = 32'h004; bus_write = 1'b1; bus_size = 3'd2;
    @(negedge clk);
    go_idle(); bus_wdata = 32'hDEADBEEF;
    check(ready_out === 1'b1 && resp_err === 1'b0, req, {30'd0, ready_out, resp_err}, 32'h2);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] rd; int nw; bit fe, le;
    rst_n = 1'b0; go_idle(); bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: quiet response out of reset
    check(ready_out === 1'b1, "R7 ready", {31'd0, ready_out}, 32'd1);
    check(resp_err === 1'b0, "R7 resp", {31'd0, resp_err}, 32'd0);
    check(bus_rdata === 32'd0, "R7 rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;

    // Table walk: R4 wait count, R5/R6 response, R9/R10 read data
    for (int i = 0; i < 16; i++) begin
      xfer(VTAB[i].wr, VTAB[i].sz, VTAB[i].a, VTAB[i].wd, rd, nw, fe, le);
      if (VTAB[i].oob) begin
        check(nw == 1, "R5 one low cycle", nw, 1);
        check(fe === 1'b1, "R5 first cycle error", {31'd0, fe}, 32'd1);
        check(le === 1'b1, "R5 second cycle error", {31'd0, le}, 32'd1);
      end else begin
        check(nw == WAITS, "R4 wait count", nw, WAITS);
        check(le === 1'b0, "R6 okay", {31'd0, le}, 32'd0);
        if (!VTAB[i].wr) check(rd === VTAB[i].exp, "R10 R9 read word", rd, VTAB[i].exp);
      end
    end

    // R2: unselected, IDLE and BUSY cycles write nothing
    ghost(1'b0, 2'b10, "R2 unselected");
    ghost(1'b1, 2'b00, "R2 idle");
    ghost(1'b1, 2'b01, "R2 busy");
    rd_chk(32'h004, 32'h12345678, "R2 word untouched");

    // R8/R1/R11: back-to-back writes, address phase overlapping data phase
    wr_word(32'h020, 32'h0);
    wr_word(32'h024, 32'h0);
    wr_word(32'h028, 32'h5555AAAA);
    @(negedge clk);
    sel = 1'b1; bus_trans = 2'b10; bus_addr = 32'h020; bus_write = 1'b1; bus_size = 3'd2;
    @(negedge clk);
    bus_trans = 2'b11; bus_addr = 32'h024; bus_wdata = 32'hA0A0A0A0;
    while (ready_out !== 1'b1) @(negedge clk);
    @(negedge clk);
    go_idle(); bus_addr = 32'h028; bus_wdata = 32'hA1A1A1A1;
    while (ready_out !== 1'b1) @(negedge clk);
    rd_chk(32'h020, 32'hA0A0A0A0, "R8 R1 first beat");
    rd_chk(32'h024, 32'hA1A1A1A1, "R8 R1 second beat");
    rd_chk(32'h028, 32'h5555AAAA, "R1 live address unused");

    // R3: BUSY between burst beats
    @(negedge clk);
    sel = 1'b1; bus_trans = 2'b10; bus_addr = 32'h030; bus_write = 1'b1; bus_size = 3'd2;
    @(negedge clk);
    bus_trans = 2'b01; bus_addr = 32'h034; bus_wdata = 32'h30303030;
    while (ready_out !== 1'b1) @(negedge clk);
    @(negedge clk);
    check(ready_out === 1'b1 && resp_err === 1'b0, "R3 busy no wait", {30'd0, ready_out, resp_err}, 32'h2);
    bus_trans = 2'b11; bus_wdata = 32'h0;
    @(negedge clk);
    go_idle(); bus_addr = 32'h0F0; bus_wdata = 32'h34343434;
    nw = 0;
    while (ready_out !== 1'b1) begin nw++; @(negedge clk); end
    check(nw == WAITS, "R3 R4 seq beat waits", nw, WAITS);
    rd_chk(32'h030, 32'h30303030, "R3 beat before busy");
    rd_chk(32'h034, 32'h34343434, "R3 beat after busy");

    done = 1'b1;
    report();
  end
endmodule